// File: doc/BRIEF.md
# Streaming Max-Pooling Datapath

This block reduces a raster-scanned square image by taking the maximum of each non-overlapping square window. Pixels enter one per clock while an enable is high. A band is one horizontal strip of windows, which is `POOL` image rows tall. While a band is being scanned, the block keeps two stores. The first is a running-maximum register for the window currently being visited. The second is a shift register that holds one partial maximum per window across the row.

At the end of each window's segment within a row, the partial maximum enters the shift register. On the next row, the block picks that same partial maximum up again from the register head, so no raw pixel line buffer is needed. On the bottom row of the band, each finished maximum appears on the output with a one-cycle valid strobe. When a band finishes, all window state is cleared. A band counter raises an end-of-image flag after `ROW_LEN/POOL` bands.

The block is built with a row length `ROW_LEN` (default 26), a window edge `POOL` (default 2) and a pixel width `PIX_W` (default 8, unsigned). Internally, a 2-bit operand code chooses what the incoming pixel is compared against: 00 for the running maximum, 01 for the shift-register head and 10 for a cleared operand.

Top module: `maxpool_stream`

## Requirements
- R1: While `rst_n` is low at a rising edge, all state is cleared, and afterwards `pool_out`, `pool_vld` and `op_done` read 0.
- R2: Every strobed `pool_out` equals the maximum of its `POOL`x`POOL` window. Windows are reported band by band, left to right within a band.
- R3: `pool_vld` is high for exactly one cycle: the cycle after the edge that accepts the bottom-right pixel of a window. A full image gives exactly `(ROW_LEN/POOL)^2` strobes.
- R4: When `pix_en` is low, nothing advances and the value on `pix_in` is ignored. Idle gaps of any length leave the output sequence unchanged.
- R5: A window maximum that lies in an upper row of the band is carried through the shift register and reported correctly, even when every later pixel of that window is 0.
- R6: Each band starts from cleared state, so no value from an earlier band affects a later one.
- R7: `op_done` rises together with the last strobe of an image. It stays high through idle cycles and falls at the edge that accepts the next pixel.
- R8: `pool_out` holds its last strobed value between strobes.
- R9: Pixel values 0 and 2^PIX_W-1 are handled at the range limits.
- R10: A reset part-way through an image discards the partial state, and the next full image is pooled correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Pixel accept enable |
| pix_in | input | PIX_W | Unsigned pixel value |
| pool_out | output | PIX_W | Pooled window maximum |
| pool_vld | output | 1 | One-cycle strobe marking a new `pool_out` |
| op_done | output | 1 | High once the last band of the image has completed |

## Verification
The bench uses the default build: 26-pixel rows and a 2x2 window, which gives 13 windows per row and 13 bands. At this size, every window position of a whole 26x26 image is compared against a max-pool computed arithmetically in the bench. This covers both the first and last window of a row and the first and last band of the image. The small configuration keeps each image short enough to stream seven complete images, with idle gaps, sparse maxima, band-alternating extremes and a reset part-way through an image.

// File: rtl/maxpool_pkg.sv
// Package: shared types for the streaming max-pool block.
// Assumes: nothing beyond IEEE 1800-2017.
package maxpool_pkg;

    // Operand chosen for comparison against the incoming pixel.
    typedef enum logic [1:0] {
        OPND_MAX  = 2'b00,   // running maximum of the current window
        OPND_PSR  = 2'b01,   // partial maximum from the previous row (shift-register head)
        OPND_ZERO = 2'b10    // cleared operand at the start of a band
    } opnd_sel_e;

endpackage

// File: rtl/maxpool_seq.sv
// Module: maxpool_seq
// Tracks the raster position inside a band (pixel within window segment,
// window within row, row within band) and the band count of the image.
// It derives the operand select and the segment/window/band end markers.
// Assumes: ROW_LEN is a multiple of POOL, and the image is ROW_LEN rows tall.
module maxpool_seq
    import maxpool_pkg::*;
#(
    parameter int ROW_LEN = 26,
    parameter int POOL    = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    output opnd_sel_e sel,
    output logic      seg_last,
    output logic      win_last,
    output logic      band_last,
    output logic      img_done
);
    localparam int NB     = ROW_LEN / POOL;
    localparam int SEG_W  = (POOL > 1) ? $clog2(POOL) : 1;
    localparam int NB_W   = (NB > 1) ? $clog2(NB) : 1;
    localparam int BAND_W = $clog2(NB + 1);

    logic [SEG_W-1:0]  seg_q;
    logic [NB_W-1:0]   nb_q;
    logic [SEG_W-1:0]  row_q;
    logic [BAND_W-1:0] band_q;
    logic              nb_last;
    logic              row_last;

    // Purpose: decode the position markers from the counters.
    always_comb begin
        seg_last  = (seg_q == SEG_W'(POOL - 1));
        nb_last   = (nb_q == NB_W'(NB - 1));
        row_last  = (row_q == SEG_W'(POOL - 1));
        win_last  = seg_last && row_last;
        band_last = win_last && nb_last;
        img_done  = (band_q == BAND_W'(NB));
    end

    // Purpose: pick the comparison operand for the pixel at the current position.
    always_comb begin
        if (seg_q != '0)      sel = OPND_MAX;
        else if (row_q == '0) sel = OPND_ZERO;
        else                  sel = OPND_PSR;
    end

    // Purpose: step the position counters on every accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= '0;
            nb_q  <= '0;
            row_q <= '0;
        end else if (adv) begin
            seg_q <= seg_last ? '0 : seg_q + 1'b1;
            if (seg_last) begin
                nb_q <= nb_last ? '0 : nb_q + 1'b1;
                if (nb_last)
                    row_q <= row_last ? '0 : row_q + 1'b1;
            end
        end
    end

    // Purpose: count completed bands, and restart at the first pixel of a new image.
    always_ff @(posedge clk) begin
        if (!rst_n)
            band_q <= '0;
        else if (adv) begin
            if (img_done)       band_q <= band_last ? BAND_W'(1) : '0;
            else if (band_last) band_q <= band_q + 1'b1;
        end
    end

    // R6: a completed band returns every position counter to the origin.
    a_r6_band_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && band_last) |=> (seg_q == '0 && nb_q == '0 && row_q == '0));

    // R4: counters hold while no pixel is accepted.
    a_r4_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(seg_q) && $stable(nb_q) && $stable(row_q)));

endmodule

// File: rtl/maxpool_cmp.sv
// Module: maxpool_cmp
// Operand multiplexer followed by an unsigned magnitude comparator.
// Returns the larger of the pixel and the selected operand.
// Assumes: all values unsigned, and sel is one of the three defined codes.
module maxpool_cmp
    import maxpool_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] pix,
    input  logic [PIX_W-1:0] run_max,
    input  logic [PIX_W-1:0] psr_head,
    input  opnd_sel_e        sel,
    output logic [PIX_W-1:0] res
);
    logic [PIX_W-1:0] opnd;

    // Purpose: choose the operand and keep the larger value.
    always_comb begin
        unique case (sel)
            OPND_MAX: opnd = run_max;
            OPND_PSR: opnd = psr_head;
            default:  opnd = '0;
        endcase
        res = (pix > opnd) ? pix : opnd;
        // R2: the result bounds both inputs and is one of them.
        a_r2_max_bound: assert ((res >= pix) && (res >= opnd) && ((res == pix) || (res == opnd)));
    end

endmodule

// File: rtl/maxpool_psr.sv
// Module: maxpool_psr
// A row-length shift register of partial window maxima. A shift pushes at
// the tail and advances the head by one entry. A flush clears every entry.
// Assumes: exactly one shift per window segment, so the head always holds
// the partial maximum of the window now being entered.
module maxpool_psr #(
    parameter int PIX_W = 8,
    parameter int DEPTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic             flush,
    input  logic [PIX_W-1:0] din,
    output logic [PIX_W-1:0] head
);
    logic [PIX_W-1:0] stage_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        // Purpose: one register stage, loaded from its upper neighbour or from the tail input.
        always_ff @(posedge clk) begin
            if (!rst_n || flush)
                stage_q[i] <= '0;
            else if (shift)
                stage_q[i] <= (i == DEPTH - 1) ? din : stage_q[(i == DEPTH - 1) ? i : i + 1];
        end
    end

    assign head = stage_q[0];

    // R6: a flush leaves the head cleared.
    a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (head == '0));

    // R4: contents hold without a shift or flush.
    a_r4_psr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !flush) |=> $stable(head));

endmodule

// File: rtl/maxpool_stream.sv
// Module: maxpool_stream (top)
// Streaming non-overlapping max-pool. The running maximum of the current
// window lives in run_max_q. Partial maxima travel between rows of a band
// through maxpool_psr. Results are strobed on the bottom row of each band.
// Assumes: a square image of ROW_LEN x ROW_LEN pixels, ROW_LEN a multiple of POOL.
module maxpool_stream
    import maxpool_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int ROW_LEN = 26,
    parameter int POOL    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic [PIX_W-1:0] pix_in,
    output logic [PIX_W-1:0] pool_out,
    output logic             pool_vld,
    output logic             op_done
);
    localparam int NB = ROW_LEN / POOL;

    opnd_sel_e        sel;
    logic             seg_last;
    logic             win_last;
    logic             band_last;
    logic             img_done;
    logic [PIX_W-1:0] run_max_q;
    logic [PIX_W-1:0] psr_head;
    logic [PIX_W-1:0] res;

    maxpool_seq #(.ROW_LEN(ROW_LEN), .POOL(POOL)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (pix_en),
        .sel       (sel),
        .seg_last  (seg_last),
        .win_last  (win_last),
        .band_last (band_last),
        .img_done  (img_done)
    );

    maxpool_cmp #(.PIX_W(PIX_W)) u_cmp (
        .pix      (pix_in),
        .run_max  (run_max_q),
        .psr_head (psr_head),
        .sel      (sel),
        .res      (res)
    );

    maxpool_psr #(.PIX_W(PIX_W), .DEPTH(NB)) u_psr (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (pix_en && seg_last),
        .flush (pix_en && band_last),
        .din   (res),
        .head  (psr_head)
    );

    // Purpose: hold the running maximum, cleared at the end of every window segment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_max_q <= '0;
        else if (pix_en)
            run_max_q <= seg_last ? '0 : res;
    end

    // Purpose: capture each finished window maximum and strobe it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pool_out <= '0;
            pool_vld <= 1'b0;
        end else begin
            pool_vld <= pix_en && win_last;
            if (pix_en && win_last)
                pool_out <= res;
        end
    end

    assign op_done = img_done;

    // R3: a strobe only follows an accepted pixel.
    a_r3_vld_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        pool_vld |-> $past(pix_en));

    // R4: the running maximum holds while the enable is low.
    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(run_max_q));

    // R7: the end-of-image flag rises only with the final strobe.
    a_r7_done_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_done) |-> pool_vld);

    // R8: the output value changes only with a strobe.
    a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pool_vld |-> $stable(pool_out));

endmodule

// File: tb/tb_maxpool_stream.sv
`timescale 1ns / 1ps
module tb_maxpool_stream;
    localparam int PIX_W   = 8;
    localparam int ROW_LEN = 26;
    localparam int POOL    = 2;
    localparam int NB      = ROW_LEN / POOL;
    localparam int NWIN    = NB * NB;
    localparam int NPIX    = ROW_LEN * ROW_LEN;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pix_en = 1'b0;
    logic [PIX_W-1:0] pix_in = '0;
    logic [PIX_W-1:0] pool_out;
    logic             pool_vld;
    logic             op_done;

    logic [PIX_W-1:0] img  [NPIX];
    logic [PIX_W-1:0] expv [NWIN];
    int               out_idx = 0;
    int               checks = 0;
    int               fails = 0;
    logic [PIX_W-1:0] last_out = '0;
    bit               seen_out = 1'b0;
    bit               mon_on = 1'b0;

    always #2 clk = ~clk;

    maxpool_stream #(.PIX_W(PIX_W), .ROW_LEN(ROW_LEN), .POOL(POOL)) dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_in(pix_in),
        .pool_out(pool_out), .pool_vld(pool_vld), .op_done(op_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference max-pool computed from the image.
    task automatic compute_exp();
        for (int b = 0; b < NB; b++)
            for (int k = 0; k < NB; k++) begin
                int m = 0;
                for (int r = 0; r < POOL; r++)
                    for (int c = 0; c < POOL; c++)
                        if (int'(img[(b*POOL + r)*ROW_LEN + k*POOL + c]) > m)
                            m = int'(img[(b*POOL + r)*ROW_LEN + k*POOL + c]);
                expv[b*NB + k] = PIX_W'(m);
            end
    endtask

    // Output monitor: R2 values, R7 flag at strobes, R8 hold between strobes.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (pool_vld) begin
                if (out_idx >= NWIN)
                    chk("R3 extra strobe", out_idx, NWIN - 1);
                else begin
                    chk("R2 window max", int'(pool_out), int'(expv[out_idx]));
                    chk("R7 done at strobe", int'(op_done), int'(out_idx == NWIN - 1));
                end
                last_out = pool_out;
                seen_out = 1'b1;
                out_idx++;
            end else if (seen_out) begin
                chk("R8 hold", int'(pool_out), int'(last_out));
            end
        end
    end

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; pix_en = 1'b0; pix_in = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        seen_out = 1'b0;
        out_idx = 0;
        @(negedge clk);
        chk("R1 pool_out", int'(pool_out), 0);
        chk("R1 pool_vld", int'(pool_vld), 0);
        chk("R1 op_done", int'(op_done), 0);
    endtask

    // Stream the image. In gap mode, idle cycles carrying junk are inserted (R4).
    task automatic feed_image(input bit gaps);
        compute_exp();
        out_idx = 0;
        for (int p = 0; p < NPIX; p++) begin
            if (gaps && (p % 7 == 3)) begin
                @(posedge clk); #1 pix_en = 1'b0; pix_in = '1;
                @(posedge clk); #1 pix_in = '1;
            end
            @(posedge clk); #1 pix_en = 1'b1; pix_in = img[p];
            if (p == 1) begin
                @(negedge clk);
                chk("R7 done falls on next pixel", int'(op_done), 0);
            end
        end
        @(posedge clk); #1 pix_en = 1'b0; pix_in = '1;
        repeat (4) @(negedge clk);
        chk("R3 strobe count", out_idx, NWIN);
        chk("R7 done held idle", int'(op_done), 1);
    endtask

    initial begin
        mon_on = 1'b1;
        do_reset();

        // R2: random image, continuous stream
        for (int i = 0; i < NPIX; i++) img[i] = PIX_W'($urandom_range(0, 255));
        feed_image(1'b0);

        // R4: random image with idle gaps carrying 255 on pix_in
        for (int i = 0; i < NPIX; i++) img[i] = PIX_W'($urandom_range(0, 200));
        feed_image(1'b1);

        // R5: only the top-left pixel of each window is nonzero
        for (int i = 0; i < NPIX; i++) begin
            int r = i / ROW_LEN;
            int c = i % ROW_LEN;
            img[i] = ((r % POOL == 0) && (c % POOL == 0)) ? PIX_W'(1 + (i % 250)) : '0;
        end
        feed_image(1'b0);

        // R6: bands alternate between high and low value ranges
        for (int i = 0; i < NPIX; i++)
            img[i] = (((i / ROW_LEN) / POOL) % 2 == 0) ? PIX_W'($urandom_range(240, 255))
                                                       : PIX_W'($urandom_range(0, 15));
        feed_image(1'b0);

        // R9: all maximum, then all zero
        for (int i = 0; i < NPIX; i++) img[i] = '1;
        feed_image(1'b0);
        for (int i = 0; i < NPIX; i++) img[i] = '0;
        feed_image(1'b0);

        // R10: partial image of large values, reset, then a full image of small values
        for (int p = 0; p < ROW_LEN + 1; p++) begin
            @(posedge clk); #1 pix_en = 1'b1; pix_in = 8'd250;
        end
        do_reset();
        for (int i = 0; i < NPIX; i++) img[i] = PIX_W'($urandom_range(0, 100));
        feed_image(1'b0);
        chk("R10 strobes after reset", out_idx, NWIN);

        mon_on = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule